// File: doc/BRIEF.md
# Progression Sieve Threshold Accumulator

This block walks a range of sieve positions, one position per clock. It holds two small tables of arithmetic progressions, one for the rational side and one for the algebraic side. The algebraic table is the larger of the two. Each progression carries a prime step, a phase and an 8-bit weight that approximates the logarithm of the prime.

At every position, each side adds up the weights of the progressions that land there. A position is reported as a candidate only when the rational total and the algebraic total both lie strictly above their own thresholds.

The tables are loaded through a simple write port while the block is idle. A single start pulse then runs one scan from a first index to a last index, inclusive. Candidates come out as an index together with a one-cycle valid strobe. A completion flag marks the end of the scan.

Top module: `sieve_threshold_top`

## Requirements
- R1: After reset, busy, done and hitValid are low, and every table entry has weight 0, prime 1 and phase 0. A scan run before any write therefore reports no candidate.
- R2: A write (cfgWe high while busy is low) stores cfgPrime, cfgPhase and cfgWeight in entry cfgSlot of the table chosen by cfgSide (0 = rational, 1 = algebraic). A write made while busy is high is ignored. A write whose slot number is not below that side's entry count is also ignored.
- R3: When scanStart is seen while the block is idle, a scan begins. Busy goes high at that edge, and the indices scanFirst to scanLast are processed one per clock, in increasing order. A scanStart seen while busy is ignored, as are any changes to scanFirst and scanLast during the scan.
- R4: A progression with prime p (p at least 1) and phase d lands on the scan indices scanFirst + d + k·p, for every k ≥ 0.
- R5: The total for each side at an index is the sum of the weights of that side's progressions landing there. The total is clamped at 2^SUM_W − 1 (511 by default) and never wraps.
- R6: One clock after an index is processed, hitValid is high for exactly one cycle if and only if the rational total > thrRat and the algebraic total > thrAlg. The comparison is strict. hitIndex then carries that index.
- R7: Done rises at the same edge that delivers the result for scanLast, and busy falls at that edge. Done stays high until the next accepted start.
- R8: Every scan restarts each progression from its stored phase, so repeating a scan with the same settings gives the same candidates.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfgWe | input | 1 | Table write strobe |
| cfgSide | input | 1 | Table select: 0 rational, 1 algebraic |
| cfgSlot | input | SLOT_W | Entry number within the selected table |
| cfgPrime | input | P_W | Step of the progression |
| cfgPhase | input | IDX_W | Offset of the first landing from scanFirst |
| cfgWeight | input | W_W | Weight added on each landing |
| thrRat | input | SUM_W | Rational threshold (strict) |
| thrAlg | input | SUM_W | Algebraic threshold (strict) |
| scanStart | input | 1 | Start pulse |
| scanFirst | input | IDX_W | First index of the scan |
| scanLast | input | IDX_W | Last index of the scan |
| busy | output | 1 | Scan in progress |
| done | output | 1 | Last scan finished |
| hitValid | output | 1 | Candidate strobe |
| hitIndex | output | IDX_W | Candidate index |

## Verification
The bench computes each side's total from its own copy of the tables. A design that checks for a threshold with ≥ instead of > would report positions whose total only equals the threshold. A design that lets the algebraic total wrap would lose the positions where four heavy weights push the total past 511.

The bench also writes a table entry and pulses start in the middle of a scan. A design that accepts either one would change the candidates that follow, or move the moment done rises.

A write to a rational slot number above the table size is tested, since a design that does not range-check the slot would corrupt an entry. Repeated scans are compared against each other, since a design that keeps its countdowns from the previous scan would shift every landing.

// File: rtl/sieve_pkg.sv
package sieve_pkg;
  // Strobes passed from the control unit to the datapath.
  typedef struct packed {
    logic load;  // reload countdowns from the stored phases
    logic step;  // process the current index
  } sieveStrobe_t;
endpackage

// File: rtl/sieve_ctrl.sv
module sieve_ctrl
  import sieve_pkg::*;
#(
  parameter int IDX_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scanStart,
  input  logic [IDX_W-1:0] scanFirst,
  input  logic [IDX_W-1:0] scanLast,
  output sieveStrobe_t     strobe,
  output logic [IDX_W-1:0] curIdx,
  output logic             busy,
  output logic             done
);
  typedef enum logic {IDLE, SCAN} ctrlState_t;
  ctrlState_t state;
  logic [IDX_W-1:0] lastReg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= IDLE;
      curIdx  <= '0;
      lastReg <= '0;
      done    <= 1'b0;
    end else if (state == IDLE) begin
      if (scanStart) begin
        state   <= SCAN;
        curIdx  <= scanFirst;
        lastReg <= scanLast;
        done    <= 1'b0;
      end
    end else if (curIdx == lastReg) begin
      state <= IDLE;
      done  <= 1'b1;
    end else begin
      curIdx <= curIdx + IDX_W'(1);
    end
  end

  assign busy        = (state == SCAN);
  assign strobe.load = (state == IDLE) && scanStart;
  assign strobe.step = (state == SCAN);

  // R7: completion flag only while idle
  a_r7_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  // R3: a scan only starts from a start pulse
  a_r3_start_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(scanStart));
endmodule

// File: rtl/sieve_bank.sv
module sieve_bank
  import sieve_pkg::*;
#(
  parameter int N      = 2,
  parameter int SLOT_W = 1,
  parameter int IDX_W  = 16,
  parameter int P_W    = 8,
  parameter int W_W    = 8,
  parameter int SUM_W  = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wrEn,
  input  logic [SLOT_W-1:0] wrSlot,
  input  logic [P_W-1:0]    wrPrime,
  input  logic [IDX_W-1:0]  wrPhase,
  input  logic [W_W-1:0]    wrWeight,
  input  sieveStrobe_t      strobe,
  input  logic              busy,
  output logic [SUM_W-1:0]  sum
);
  localparam int RAW_W  = W_W + $clog2(N + 1);
  localparam int FULL_W = (RAW_W > SUM_W) ? RAW_W : SUM_W + 1;
  localparam logic [FULL_W-1:0] SUM_CAP = FULL_W'((1 << SUM_W) - 1);

  logic [P_W-1:0]   prime  [N];
  logic [IDX_W-1:0] phase  [N];
  logic [W_W-1:0]   weight [N];
  logic [IDX_W-1:0] cd     [N];
  logic             slotOk;
  logic [FULL_W-1:0] full;

  assign slotOk = int'(wrSlot) < N;

  for (genvar e = 0; e < N; e++) begin : g_entry
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        prime[e]  <= P_W'(1);
        phase[e]  <= '0;
        weight[e] <= '0;
      end else if (wrEn && slotOk && (wrSlot == SLOT_W'(e))) begin
        prime[e]  <= wrPrime;
        phase[e]  <= wrPhase;
        weight[e] <= wrWeight;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        cd[e] <= '0;
      else if (strobe.load)
        cd[e] <= phase[e];
      else if (strobe.step)
        cd[e] <= (cd[e] == '0) ? (IDX_W'(prime[e]) - IDX_W'(1)) : (cd[e] - IDX_W'(1));
    end

    // R2: table contents are frozen while a scan runs
    a_r2_frozen_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> ($stable(weight[e]) && $stable(prime[e]) && $stable(phase[e])));
  end

  always_comb begin
    full = '0;
    for (int e = 0; e < N; e++)
      if (cd[e] == '0) full = full + FULL_W'(weight[e]);
  end

  assign sum = (full > SUM_CAP) ? SUM_CAP[SUM_W-1:0] : full[SUM_W-1:0];
endmodule

// File: rtl/sieve_datapath.sv
module sieve_datapath
  import sieve_pkg::*;
#(
  parameter int N_RAT  = 2,
  parameter int N_ALG  = 4,
  parameter int SLOT_W = 2,
  parameter int IDX_W  = 16,
  parameter int P_W    = 8,
  parameter int W_W    = 8,
  parameter int SUM_W  = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfgWe,
  input  logic              cfgSide,
  input  logic [SLOT_W-1:0] cfgSlot,
  input  logic [P_W-1:0]    cfgPrime,
  input  logic [IDX_W-1:0]  cfgPhase,
  input  logic [W_W-1:0]    cfgWeight,
  input  logic [SUM_W-1:0]  thrRat,
  input  logic [SUM_W-1:0]  thrAlg,
  input  sieveStrobe_t      strobe,
  input  logic [IDX_W-1:0]  curIdx,
  input  logic              busy,
  output logic              hitValid,
  output logic [IDX_W-1:0]  hitIndex
);
  logic [SUM_W-1:0] ratSum;
  logic [SUM_W-1:0] algSum;
  logic ratWe;
  logic algWe;

  assign ratWe = cfgWe && !busy && !cfgSide;
  assign algWe = cfgWe && !busy && cfgSide;

  sieve_bank #(.N(N_RAT), .SLOT_W(SLOT_W), .IDX_W(IDX_W), .P_W(P_W), .W_W(W_W), .SUM_W(SUM_W)) ratBank_i (
    .clk(clk), .rst_n(rst_n), .wrEn(ratWe), .wrSlot(cfgSlot), .wrPrime(cfgPrime),
    .wrPhase(cfgPhase), .wrWeight(cfgWeight), .strobe(strobe), .busy(busy), .sum(ratSum));

  sieve_bank #(.N(N_ALG), .SLOT_W(SLOT_W), .IDX_W(IDX_W), .P_W(P_W), .W_W(W_W), .SUM_W(SUM_W)) algBank_i (
    .clk(clk), .rst_n(rst_n), .wrEn(algWe), .wrSlot(cfgSlot), .wrPrime(cfgPrime),
    .wrPhase(cfgPhase), .wrWeight(cfgWeight), .strobe(strobe), .busy(busy), .sum(algSum));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hitValid <= 1'b0;
      hitIndex <= '0;
    end else begin
      hitValid <= strobe.step && (ratSum > thrRat) && (algSum > thrAlg);
      if (strobe.step) hitIndex <= curIdx;
    end
  end

  // R6: a reported candidate passed both sides at the previous index
  a_r6_both_pass: assert property (@(posedge clk) disable iff (!rst_n)
    hitValid |-> (($past(ratSum) > $past(thrRat)) && ($past(algSum) > $past(thrAlg))));
endmodule

// File: rtl/sieve_threshold_top.sv
module sieve_threshold_top
  import sieve_pkg::*;
#(
  parameter int N_RAT = 2,
  parameter int N_ALG = 4,
  parameter int IDX_W = 16,
  parameter int P_W   = 8,
  parameter int W_W   = 8,
  parameter int SUM_W = 9,
  localparam int MAX_N  = (N_ALG > N_RAT) ? N_ALG : N_RAT,
  localparam int SLOT_W = (MAX_N > 2) ? $clog2(MAX_N) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfgWe,
  input  logic              cfgSide,
  input  logic [SLOT_W-1:0] cfgSlot,
  input  logic [P_W-1:0]    cfgPrime,
  input  logic [IDX_W-1:0]  cfgPhase,
  input  logic [W_W-1:0]    cfgWeight,
  input  logic [SUM_W-1:0]  thrRat,
  input  logic [SUM_W-1:0]  thrAlg,
  input  logic              scanStart,
  input  logic [IDX_W-1:0]  scanFirst,
  input  logic [IDX_W-1:0]  scanLast,
  output logic              busy,
  output logic              done,
  output logic              hitValid,
  output logic [IDX_W-1:0]  hitIndex
);
  sieveStrobe_t     strobe;
  logic [IDX_W-1:0] curIdx;

  sieve_ctrl #(.IDX_W(IDX_W)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .scanStart(scanStart), .scanFirst(scanFirst),
    .scanLast(scanLast), .strobe(strobe), .curIdx(curIdx), .busy(busy), .done(done));

  sieve_datapath #(.N_RAT(N_RAT), .N_ALG(N_ALG), .SLOT_W(SLOT_W), .IDX_W(IDX_W),
                   .P_W(P_W), .W_W(W_W), .SUM_W(SUM_W)) dp_i (
    .clk(clk), .rst_n(rst_n), .cfgWe(cfgWe), .cfgSide(cfgSide), .cfgSlot(cfgSlot),
    .cfgPrime(cfgPrime), .cfgPhase(cfgPhase), .cfgWeight(cfgWeight),
    .thrRat(thrRat), .thrAlg(thrAlg), .strobe(strobe), .curIdx(curIdx), .busy(busy),
    .hitValid(hitValid), .hitIndex(hitIndex));
endmodule

// File: tb/sieve_threshold_top_tb_top.sv
`timescale 1ns/1ps
module sieve_threshold_top_tb_top;
  localparam int IDX_W = 16;
  localparam int SUM_W = 9;
  localparam int CAP   = (1 << SUM_W) - 1;
  // scan vectors: first, last, thrRat, thrAlg
  localparam int NVEC = 5;
  localparam int VEC [NVEC][4] = '{
    '{100, 130, 15, 20},
    '{0,   20,  25, 9},
    '{50,  50,  0,  0},
    '{10,  40,  49, 54},
    '{7,   30,  20, 40}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfgWe = 1'b0, cfgSide = 1'b0;
  logic [1:0] cfgSlot = '0;
  logic [7:0] cfgPrime = 8'd1;
  logic [IDX_W-1:0] cfgPhase = '0;
  logic [7:0] cfgWeight = '0;
  logic [SUM_W-1:0] thrRat = '0, thrAlg = '0;
  logic scanStart = 1'b0;
  logic [IDX_W-1:0] scanFirst = '0, scanLast = '0;
  logic busy, done, hitValid;
  logic [IDX_W-1:0] hitIndex;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  int mP [2][4];
  int mPh [2][4];
  int mW [2][4];

  always #2.5 clk = ~clk;

  sieve_threshold_top dut_i (
    .clk(clk), .rst_n(rst_n), .cfgWe(cfgWe), .cfgSide(cfgSide), .cfgSlot(cfgSlot),
    .cfgPrime(cfgPrime), .cfgPhase(cfgPhase), .cfgWeight(cfgWeight),
    .thrRat(thrRat), .thrAlg(thrAlg), .scanStart(scanStart), .scanFirst(scanFirst),
    .scanLast(scanLast), .busy(busy), .done(done), .hitValid(hitValid), .hitIndex(hitIndex));

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      fails++;
      $display("FAIL watchdog R7 actual=busy expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic chk(input string req, input bit ok, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int sideSum(input int s, input int off);
    int tot = 0;
    for (int e = 0; e < (s ? 4 : 2); e++)
      if (off >= mPh[s][e] && ((off - mPh[s][e]) % mP[s][e]) == 0) tot += mW[s][e];
    return (tot > CAP) ? CAP : tot;
  endfunction

  task automatic wr(input int side, input int slot, input int p, input int ph,
                    input int w, input bit apply);
    cfgWe = 1'b1; cfgSide = side[0]; cfgSlot = slot[1:0];
    cfgPrime = p[7:0]; cfgPhase = ph[IDX_W-1:0]; cfgWeight = w[7:0];
    @(negedge clk);
    cfgWe = 1'b0;
    if (apply) begin mP[side][slot] = p; mPh[side][slot] = ph; mW[side][slot] = w; end
  endtask

  task automatic runScan(input int first, input int last, input int tr, input int ta,
                         input int injectAt, input string tag);
    int n = last - first + 1;
    thrRat = tr[SUM_W-1:0]; thrAlg = ta[SUM_W-1:0];
    scanFirst = first[IDX_W-1:0]; scanLast = last[IDX_W-1:0]; scanStart = 1'b1;
    @(negedge clk);
    scanStart = 1'b0;
    chk({tag, " R3 busy after start"}, busy === 1'b1, int'(busy), 1);
    for (int k = 0; k < n; k++) begin
      bit expHit;
      @(negedge clk);
      cfgWe = 1'b0; scanStart = 1'b0;
      expHit = (sideSum(0, k) > tr) && (sideSum(1, k) > ta);
      chk({tag, " R6 hitValid"}, hitValid === expHit, int'(hitValid), int'(expHit));
      if (expHit)
        chk({tag, " R4 hitIndex"}, hitIndex === (first + k), int'(hitIndex), first + k);
      chk({tag, " R7 done timing"}, done === (k == n - 1), int'(done), int'(k == n - 1));
      if (k == injectAt) begin
        // R2/R3: write and start while busy must be ignored
        cfgWe = 1'b1; cfgSide = 1'b0; cfgSlot = 2'd0;
        cfgPrime = 8'd1; cfgPhase = '0; cfgWeight = 8'd255;
        scanStart = 1'b1; scanFirst = '0; scanLast = 16'd3;
      end
    end
    @(negedge clk);
    chk({tag, " R7 done held"}, done === 1'b1 && busy === 1'b0, int'(done), 1);
    chk({tag, " R6 single pulse"}, hitValid === 1'b0, int'(hitValid), 0);
  endtask

  initial begin
    for (int s = 0; s < 2; s++)
      for (int e = 0; e < 4; e++) begin mP[s][e] = 1; mPh[s][e] = 0; mW[s][e] = 0; end
    repeat (3) @(negedge clk);
    chk("R1 busy reset", busy === 1'b0, int'(busy), 0);
    chk("R1 done reset", done === 1'b0, int'(done), 0);
    chk("R1 hitValid reset", hitValid === 1'b0, int'(hitValid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: empty tables report nothing
    runScan(0, 5, 0, 0, -1, "R1 empty");

    wr(0, 0, 3, 0, 20, 1);
    wr(0, 1, 5, 2, 30, 1);
    wr(1, 0, 2, 1, 10, 1);
    wr(1, 1, 7, 0, 40, 1);
    wr(1, 2, 3, 1, 15, 1);
    // R4/R5/R6: vector table
    for (int v = 0; v < NVEC; v++)
      runScan(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3], -1, "R5 vec");

    // R2/R3: mid-scan write and start ignored
    runScan(200, 215, 15, 20, 3, "R3 busy inject");
    // R8: repeat scan gives same result (also confirms the busy write was dropped, R2)
    runScan(200, 215, 15, 20, -1, "R8 rescan");
    // R2: rational slot 3 is out of range
    wr(0, 3, 1, 0, 255, 0);
    runScan(0, 10, 15, 20, -1, "R2 slot range");

    // R5: saturation, 4x200 = 800 clamps to 511
    wr(0, 0, 1, 0, 1, 1);
    for (int e = 0; e < 4; e++) wr(1, e, 1, 0, 200, 1);
    runScan(0, 7, 0, 510, -1, "R5 sat pass");
    runScan(0, 7, 0, 511, -1, "R5 sat cap");

    repeat (3) @(negedge clk);
    chk("R7 done persists", done === 1'b1, int'(done), 1);
    chk("R7 idle after done", busy === 1'b0, int'(busy), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule